// File: doc/BRIEF.md
# Byte-Lane Write Strobe Control for a Synchronous SRAM

This block turns the write controls of a synchronous SRAM into registered per-lane write strobes. The word is 36 bits wide and split into four 9-bit lanes, each made of eight data bits and one parity bit. All controls are active low and are sampled on the rising clock edge: a chip select, a global write, a byte-write gate and four lane selects. The registered strobes commit lane-masked writes into a behavioural memory array. A registered flag tells the read path to hold its outputs off while a write is in flight.

The global write wins over everything else and writes all four lanes. The lane selects matter only while the byte-write gate is low. With the gate high, only the global write can start a write. The address and write data are captured at the same edge as the controls, and the strobes apply to that captured address and data one edge later. A selected cycle that writes nothing is a read. Its data reaches the output after a second edge.

Top module: `sram_lane_write`

## Requirements
- R1: After reset, `outDisable` is 0 and `dataOut` is all zeros.
- R2: If `chipSelN` and `globalWrN` are both low at an edge, all four lanes at the captured address are written. This holds whatever `byteGateN` and `laneSelN` are.
- R3: If `chipSelN` and `byteGateN` are low and `globalWrN` is high at an edge, exactly the lanes whose `laneSelN` bit is low are written. The other lanes keep their contents.
- R4: If `byteGateN` and `globalWrN` are both high, `laneSelN` is ignored. No lane is written and `outDisable` stays 0.
- R5: Lane i covers data bits `[8*i+7 : 8*i]` of `dataIn` and `dataOut`, plus parity bit `32+i`. Lane select bit i controls lane i.
- R6: After an edge that samples a write to at least one lane, `outDisable` is 1 and `dataOut` is all zeros until the next edge.
- R7: If `chipSelN` is high at an edge, nothing is written and `outDisable` is 0 after that edge, whatever the other write controls are.
- R8: A selected edge with no lane written is a read of the address captured there. `dataOut` shows that word after the following edge. A read issued at the edge right after a write returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| chipSelN | input | 1 | Chip selected when low |
| globalWrN | input | 1 | Write all lanes when low |
| byteGateN | input | 1 | Lets the lane selects through when low |
| laneSelN | input | 4 | Per-lane write selects, active low |
| addrIn | input | ADDR_W | Word address |
| dataIn | input | 36 | Write data: bits 31:0 data, bits 35:32 parity |
| dataOut | output | 36 | Read data, zero while outputs are disabled |
| outDisable | output | 1 | High in the cycle after a write is sampled |

## Verification
A commit to memory and a new read request can fall in the same cycle. The write strobes from one edge take effect at the next edge, and a read may be captured at that same edge. The bench provokes this by writing a word and issuing a read of the same address at the very next edge. It then checks that the returned word carries the new lanes merged with the old ones, as the model predicts. It also holds the global write and the gated lane selects active together. This confirms that the global write decides the lane set, and that an ungated select pattern leaves both the memory and `outDisable` untouched.

// File: rtl/lanewr_pkg.sv
package lanewr_pkg;
  parameter int LANES     = 4;
  parameter int BYTE_BITS = 8;
  localparam int LANE_BITS = BYTE_BITS + 1;
  localparam int WORD_BITS = LANES * LANE_BITS;
  localparam int PAR_BASE  = LANES * BYTE_BITS;

  typedef struct packed {
    logic [LANES-1:0] lane;
    logic             rdReq;
  } strobe_t;
endpackage

// File: rtl/lanewr_ctrl.sv
module lanewr_ctrl
  import lanewr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSelN,
  input  logic             globalWrN,
  input  logic             byteGateN,
  input  logic [LANES-1:0] laneSelN,
  output strobe_t          strb,
  output logic             outDisable
);
  logic [LANES-1:0] laneNext;
  logic             rdNext;

  always_comb begin
    laneNext = '0;
    if (!chipSelN) begin
      if (!globalWrN)      laneNext = '1;
      else if (!byteGateN) laneNext = ~laneSelN;
    end
    rdNext = !chipSelN && (laneNext == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strb       <= '0;
      outDisable <= 1'b0;
    end else begin
      strb.lane  <= laneNext;
      strb.rdReq <= rdNext;
      outDisable <= |laneNext;
    end
  end

  // R2
  glob_all_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && !globalWrN) |=> (strb.lane == '1 && outDisable));

  // R3
  gated_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && globalWrN && !byteGateN) |=> (strb.lane == ~$past(laneSelN)));

  // R4
  ungated_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (globalWrN && byteGateN) |=> (strb.lane == '0 && !outDisable));

  // R7
  desel_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    chipSelN |=> (strb.lane == '0 && !strb.rdReq && !outDisable));
endmodule

// File: rtl/lanewr_array.sv
module lanewr_array
  import lanewr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic [WORD_BITS-1:0] dataIn,
  input  strobe_t              strb,
  input  logic                 outDisable,
  output logic [WORD_BITS-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0]    addrReg;
  logic [WORD_BITS-1:0] dinReg;
  logic [WORD_BITS-1:0] outReg;
  logic [WORD_BITS-1:0] rdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dinReg  <= '0;
    end else begin
      addrReg <= addrIn;
      dinReg  <= dataIn;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : laneBank
    logic [LANE_BITS-1:0] laneMem [DEPTH];
    logic [LANE_BITS-1:0] laneWr;
    logic [LANE_BITS-1:0] laneRd;

    assign laneWr = {dinReg[PAR_BASE+g], dinReg[g*BYTE_BITS +: BYTE_BITS]};
    assign laneRd = laneMem[addrReg];

    always_ff @(posedge clk) begin
      if (strb.lane[g]) laneMem[addrReg] <= laneWr;
    end

    assign rdWord[g*BYTE_BITS +: BYTE_BITS] = laneRd[BYTE_BITS-1:0];
    assign rdWord[PAR_BASE+g]               = laneRd[BYTE_BITS];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           outReg <= '0;
    else if (strb.rdReq) outReg <= rdWord;
  end

  assign dataOut = outDisable ? '0 : outReg;

  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdReq |-> (strb.lane == '0));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lane != '0) |=> $stable(outReg));
endmodule

// File: rtl/sram_lane_write.sv
module sram_lane_write
  import lanewr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chipSelN,
  input  logic                 globalWrN,
  input  logic                 byteGateN,
  input  logic [LANES-1:0]     laneSelN,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic [WORD_BITS-1:0] dataIn,
  output logic [WORD_BITS-1:0] dataOut,
  output logic                 outDisable
);
  strobe_t strb;

  lanewr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .globalWrN(globalWrN),
    .byteGateN(byteGateN), .laneSelN(laneSelN), .strb(strb),
    .outDisable(outDisable)
  );

  lanewr_array #(.ADDR_W(ADDR_W)) uArray (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dataIn(dataIn), .strb(strb),
    .outDisable(outDisable), .dataOut(dataOut)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!outDisable || rstN));
endmodule

// File: tb/tb_sram_lane_write.sv
module tb_sram_lane_write;
  localparam int AW = 4;
  localparam time CYC = 20ns;

  logic        clk = 0;
  logic        rstN = 0;
  logic        chipSelN = 1, globalWrN = 1, byteGateN = 1;
  logic [3:0]  laneSelN = 4'hF;
  logic [AW-1:0] addrIn = '0;
  logic [35:0] dataIn = '0;
  logic [35:0] dataOut;
  logic        outDisable;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [35:0] model [16];

  sram_lane_write #(.ADDR_W(AW)) dut (.*);

  always #(CYC/2) clk = ~clk;

  task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expLanes(logic cs, logic gw, logic bg, logic [3:0] sel);
    if (cs) return 4'h0;
    if (!gw) return 4'hF;
    if (!bg) return ~sel;
    return 4'h0;
  endfunction

  function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] d, logic [3:0] ln);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (ln[i]) begin
      r[8*i +: 8] = d[8*i +: 8];
      r[32+i]     = d[32+i];
    end
    return r;
  endfunction

  task automatic setIdle();
    chipSelN = 1; globalWrN = 1; byteGateN = 1; laneSelN = 4'hF;
  endtask

  // drive at negedge, edge k samples, check after k; leaves next negedge
  task automatic writeOp(string tag, logic cs, logic gw, logic bg, logic [3:0] sel,
                         logic [AW-1:0] a, logic [35:0] d, bit idleAfter = 1);
    logic [3:0] ln = expLanes(cs, gw, bg, sel);
    chipSelN = cs; globalWrN = gw; byteGateN = bg; laneSelN = sel;
    addrIn = a; dataIn = d;
    @(posedge clk); @(negedge clk);
    check({tag, " outDisable"}, {35'b0, outDisable}, {35'b0, |ln});
    if (|ln) check({tag, " R6 dataOut off"}, dataOut, 36'h0);
    model[a] = merge(model[a], d, ln);
    if (idleAfter) setIdle();
  endtask

  task automatic readCheck(string tag, logic [AW-1:0] a);
    chipSelN = 0; globalWrN = 1; byteGateN = 1; laneSelN = 4'h0; addrIn = a;
    @(posedge clk); @(negedge clk);
    setIdle();
    @(posedge clk); @(negedge clk);
    check(tag, dataOut, model[a]);
  endtask

  task automatic testReset();
    check("R1 outDisable", {35'b0, outDisable}, 36'h0);
    check("R1 dataOut", dataOut, 36'h0);
  endtask

  task automatic testGlobal();
    for (int i = 0; i < 4; i++) begin
      writeOp("R2 global", 0, 0, i[0], 4'hF, i[AW-1:0], {4'(i+5), 32'hA5A5_0000 + i});
      readCheck("R2 readback", i[AW-1:0]);
    end
    writeOp("R2 global over gate", 0, 0, 0, 4'b1010, 4'd2, 36'hF_1234_5678);
    readCheck("R2 all lanes", 4'd2);
  endtask

  task automatic testLanes();
    writeOp("R5 seed", 0, 0, 1, 4'hF, 4'd5, 36'h0_0000_0000);
    for (int i = 0; i < 4; i++) begin
      writeOp("R3 one lane", 0, 1, 0, ~(4'b1 << i), 4'd5, 36'hF_FFFF_FFFF);
      readCheck("R5 lane map", 4'd5);
    end
    writeOp("R3 two lanes", 0, 1, 0, 4'b0110, 4'd1, 36'h5_C3C3_C3C3);
    readCheck("R3 readback", 4'd1);
    writeOp("R3 no lanes", 0, 1, 0, 4'hF, 4'd1, 36'h0);
    readCheck("R3 none kept", 4'd1);
  endtask

  task automatic testUngated();
    writeOp("R4 ignored sel", 0, 1, 1, 4'h0, 4'd3, 36'h0_DEAD_BEEF);
    readCheck("R4 memory unchanged", 4'd3);
  endtask

  task automatic testDeselect();
    writeOp("R7 deselected", 1, 0, 0, 4'h0, 4'd0, 36'hA_0BAD_F00D);
    readCheck("R7 memory unchanged", 4'd0);
  endtask

  task automatic testBackToBack();
    writeOp("R8 write", 0, 1, 0, 4'b1100, 4'd7, 36'h0_0000_0000);
    writeOp("R8 write", 0, 1, 0, 4'b0011, 4'd7, 36'hC_1122_3344, 0);
    readCheck("R8 read after write", 4'd7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testGlobal();
    testLanes();
    testUngated();
    testDeselect();
    testBackToBack();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule